// File: doc/BRIEF.md
# Banked Integer Register File with Status Word

This block holds the architectural integer state of a 32-bit CISC-style core: eight data registers, seven general address registers, two stack pointers (one for user mode, one for supervisor mode) and a 16-bit status word. A single write port takes results from the execution stage. A size qualifier selects byte, word or long width, and a flag steers the write to the data file or the address file. Two combinational read ports serve operand fetch. The second read port is intended as the index port for effective-address calculation.

Slot 7 of the address file is banked. It shows the user stack pointer while the supervisor bit is clear and the supervisor stack pointer while it is set, and each copy keeps its own value. Condition flags arrive from an external ALU and are captured only when a result lands in a data register.

The status word can also be written directly through a privileged port. The privileged byte (trace, supervisor, interrupt mask) is guarded: in user mode only the flag byte changes, and the attempt to write the privileged byte raises a one-cycle violation pulse for the exception logic.

Top module: `cpu_regbank`

## Requirements
- R1: A long-size write (`wr_size` 2'b10 or 2'b11) with `wr_is_addr`=0 replaces all 32 bits of the data register selected by `wr_idx`. After the next clock edge the new value is visible on a read port that selects that register.
- R2: A byte write (`wr_size` 2'b00) to a data register replaces bits 7:0 only. A word write (`wr_size` 2'b01) replaces bits 15:0 only. The remaining bits keep their value.
- R3: Every data-register write loads `cc_in`[4:0] into status bits X(4), N(3), Z(2), V(1), C(0).
- R4: A word write to an address register stores bit 15 of `wr_data` sign-extended to 32 bits. A long write stores all 32 bits.
- R5: A byte write to an address register is rejected. The register keeps its value, and `wr_reject` is high for exactly the cycle after the request.
- R6: A write to an address register or stack pointer leaves the status word unchanged.
- R7: The status word has T at bit 15, S at bit 13, the interrupt mask at bits 10:8 and the flags at bits 4:0. All other bits always read as zero. In supervisor mode a status write with `sr_wr_hi`=1 loads every defined bit from `sr_wr_data`.
- R8: Address slot 7 reads and writes the user stack pointer when S=0 and the supervisor stack pointer when S=1. The two copies are kept apart.
- R9: In user mode a status write loads only the flag byte. When `sr_wr_hi`=1, the privileged byte is left as it is and `priv_viol` pulses high for one cycle.
- R10: Either read port, selected by `*_is_addr` and `*_idx`, can return any data or address register.
- R11: Reads are combinational. A read of a register being written in the same cycle returns the value it held before the write.
- R12: Synchronous active-high reset sets the status word to 16'h2700 (S=1, mask=7, T and flags clear), clears every register and both stack pointers, and holds both pulse outputs low.
- R13: When a status-port write and a data-register write occur in the same cycle, the flag byte takes the status-port value rather than `cc_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request |
| wr_is_addr | input | 1 | 1 selects the address file, 0 the data file |
| wr_idx | input | 3 | Register number for the write |
| wr_size | input | 2 | 00 byte, 01 word, 1x long |
| wr_data | input | 32 | Write data |
| cc_in | input | 5 | Flags from the ALU: X,N,Z,V,C (bit 4 down to 0) |
| sr_wr_en | input | 1 | Status word write request |
| sr_wr_hi | input | 1 | Request also covers the privileged byte |
| sr_wr_data | input | 16 | Status write data |
| rd_a_is_addr | input | 1 | Read port A file select |
| rd_a_idx | input | 3 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_is_addr | input | 1 | Index port file select |
| rd_b_idx | input | 3 | Index port register number |
| rd_b_data | output | 32 | Index port data |
| sr_out | output | 16 | Current status word |
| wr_reject | output | 1 | Pulse: byte write to address file refused |
| priv_viol | output | 1 | Pulse: user-mode privileged status write |

## Verification
On every cycle the bound checker verifies the status-word invariants. Reserved bits stay zero, the privileged byte never moves while in user mode, and address-file writes leave the word alone. It also checks that both pulse outputs follow their triggering requests by exactly one cycle, and that data writes load the flags. Whether data lands in the right register, at the right width, with sign extension, and in the correct stack-pointer bank is a matter of stored values. Only the bench scenarios show it, by reading registers back through the ports after each write, including the same-cycle read of an old value.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int XLEN    = 32;
    localparam int SR_W    = 16;
    localparam int CC_W    = 5;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_LONG  = 2'b10,
        SZ_LONG2 = 2'b11
    } wsize_e;

    localparam int SR_T_BIT = 15;
    localparam int SR_S_BIT = 13;

    localparam logic [SR_W-1:0] SR_DEFINED = 16'hA71F;
    localparam logic [SR_W-1:0] SR_AT_RESET = 16'h2700;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    function automatic logic [XLEN-1:0] merge_sized(
        input logic [XLEN-1:0] old_v,
        input logic [XLEN-1:0] new_v,
        input wsize_e          sz
    );
        case (sz)
            SZ_BYTE: return {old_v[XLEN-1:8],  new_v[7:0]};
            SZ_WORD: return {old_v[XLEN-1:16], new_v[15:0]};
            default: return new_v;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] addr_value(
        input logic [XLEN-1:0] new_v,
        input wsize_e          sz
    );
        if (sz == SZ_WORD)
            return {{(XLEN-16){new_v[15]}}, new_v[15:0]};
        return new_v;
    endfunction

endpackage

// File: rtl/regbank_data.sv
module regbank_data
    import regbank_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int NREGS = 8,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  wsize_e        wsize,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra_idx,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  ra_q,
    output logic [W-1:0]  rb_q
);

    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (rst)
                regs[i] <= '0;
            else if (we && widx == IW'(i))
                regs[i] <= merge_sized(regs[i], wdata, wsize);
        end
    end

    assign ra_q = regs[ra_idx];
    assign rb_q = regs[rb_idx];

endmodule

// File: rtl/regbank_addr.sv
module regbank_addr
    import regbank_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int NREGS = 8,
    localparam int IW   = $clog2(NREGS),
    localparam int NGEN = NREGS - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          super_mode,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  wsize_e        wsize,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra_idx,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  ra_q,
    output logic [W-1:0]  rb_q
);

    logic [W-1:0] gen_regs [NGEN];
    logic [W-1:0] usp_q;
    logic [W-1:0] ssp_q;
    logic [W-1:0] view [NREGS];
    logic [W-1:0] wval;

    assign wval = addr_value(wdata, wsize);

    always_ff @(posedge clk) begin
        for (int i = 0; i < NGEN; i++) begin
            if (rst)
                gen_regs[i] <= '0;
            else if (we && widx == IW'(i))
                gen_regs[i] <= wval;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            usp_q <= '0;
            ssp_q <= '0;
        end else if (we && widx == IW'(NGEN)) begin
            if (super_mode)
                ssp_q <= wval;
            else
                usp_q <= wval;
        end
    end

    generate
        for (genvar g = 0; g < NGEN; g++) begin : g_view
            assign view[g] = gen_regs[g];
        end
    endgenerate
    assign view[NGEN] = super_mode ? ssp_q : usp_q;

    assign ra_q = view[ra_idx];
    assign rb_q = view[rb_idx];

endmodule

// File: rtl/regbank_status.sv
module regbank_status
    import regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cc_we,
    input  ccr_t            cc,
    input  logic            sr_we,
    input  logic            sr_hi,
    input  logic [SR_W-1:0] sr_wdata,
    output logic [SR_W-1:0] sr_q,
    output logic            viol_q
);

    logic            super_mode;
    logic [SR_W-1:0] sr_d;
    logic            viol_d;

    assign super_mode = sr_q[SR_S_BIT];

    always_comb begin
        sr_d = sr_q;
        if (cc_we)
            sr_d[CC_W-1:0] = cc;
        if (sr_we) begin
            sr_d[7:0] = sr_wdata[7:0] & SR_DEFINED[7:0];
            if (sr_hi && super_mode)
                sr_d[15:8] = sr_wdata[15:8] & SR_DEFINED[15:8];
        end
        viol_d = sr_we && sr_hi && !super_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= SR_AT_RESET;
            viol_q <= 1'b0;
        end else begin
            sr_q   <= sr_d;
            viol_q <= viol_d;
        end
    end

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
    import regbank_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_is_addr,
    input  logic [IW-1:0]   wr_idx,
    input  logic [1:0]      wr_size,
    input  logic [XLEN-1:0] wr_data,
    input  logic [CC_W-1:0] cc_in,
    input  logic            sr_wr_en,
    input  logic            sr_wr_hi,
    input  logic [SR_W-1:0] sr_wr_data,
    input  logic            rd_a_is_addr,
    input  logic [IW-1:0]   rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic            rd_b_is_addr,
    input  logic [IW-1:0]   rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    output logic [SR_W-1:0] sr_out,
    output logic            wr_reject,
    output logic            priv_viol
);

    wsize_e          size_q;
    logic            data_we;
    logic            addr_we;
    logic            byte_to_addr;
    logic            super_mode;
    logic [XLEN-1:0] d_ra, d_rb, a_ra, a_rb;

    assign size_q       = wsize_e'(wr_size);
    assign byte_to_addr = wr_en && wr_is_addr && (size_q == SZ_BYTE);
    assign data_we      = wr_en && !wr_is_addr;
    assign addr_we      = wr_en && wr_is_addr && (size_q != SZ_BYTE);
    assign super_mode   = sr_out[SR_S_BIT];

    regbank_data #(.W(XLEN), .NREGS(NREGS)) u_data (
        .clk    (clk),
        .rst    (rst),
        .we     (data_we),
        .widx   (wr_idx),
        .wsize  (size_q),
        .wdata  (wr_data),
        .ra_idx (rd_a_idx),
        .rb_idx (rd_b_idx),
        .ra_q   (d_ra),
        .rb_q   (d_rb)
    );

    regbank_addr #(.W(XLEN), .NREGS(NREGS)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .super_mode (super_mode),
        .we         (addr_we),
        .widx       (wr_idx),
        .wsize      (size_q),
        .wdata      (wr_data),
        .ra_idx     (rd_a_idx),
        .rb_idx     (rd_b_idx),
        .ra_q       (a_ra),
        .rb_q       (a_rb)
    );

    regbank_status u_status (
        .clk      (clk),
        .rst      (rst),
        .cc_we    (data_we),
        .cc       (ccr_t'(cc_in)),
        .sr_we    (sr_wr_en),
        .sr_hi    (sr_wr_hi),
        .sr_wdata (sr_wr_data),
        .sr_q     (sr_out),
        .viol_q   (priv_viol)
    );

    always_ff @(posedge clk) begin
        if (rst)
            wr_reject <= 1'b0;
        else
            wr_reject <= byte_to_addr;
    end

    assign rd_a_data = rd_a_is_addr ? a_ra : d_ra;
    assign rd_b_data = rd_b_is_addr ? a_rb : d_rb;

endmodule

// File: rtl/regbank_checker.sv
module regbank_checker
    import regbank_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IW   = $clog2(NREGS)
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic            wr_is_addr,
    input logic [IW-1:0]   wr_idx,
    input logic [1:0]      wr_size,
    input logic [XLEN-1:0] wr_data,
    input logic [CC_W-1:0] cc_in,
    input logic            sr_wr_en,
    input logic            sr_wr_hi,
    input logic [SR_W-1:0] sr_wr_data,
    input logic            rd_a_is_addr,
    input logic [IW-1:0]   rd_a_idx,
    input logic [XLEN-1:0] rd_a_data,
    input logic            rd_b_is_addr,
    input logic [IW-1:0]   rd_b_idx,
    input logic [XLEN-1:0] rd_b_data,
    input logic [SR_W-1:0] sr_out,
    input logic            wr_reject,
    input logic            priv_viol
);

    assert_reset_word_R12: assert property (@(posedge clk)
        rst |=> (sr_out == SR_AT_RESET && !wr_reject && !priv_viol));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (sr_out & ~SR_DEFINED) == '0);

    assert_flags_loaded_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_is_addr && !sr_wr_en) |=> sr_out[CC_W-1:0] == $past(cc_in));

    assert_addr_write_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_is_addr && !sr_wr_en) |=> $stable(sr_out));

    assert_user_upper_locked_R9: assert property (@(posedge clk) disable iff (rst)
        !sr_out[SR_S_BIT] |=> sr_out[15:8] == $past(sr_out[15:8]));

    assert_viol_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (sr_wr_en && sr_wr_hi && !sr_out[SR_S_BIT]) |=> priv_viol);

    assert_viol_only_when_due_R9: assert property (@(posedge clk) disable iff (rst)
        !(sr_wr_en && sr_wr_hi && !sr_out[SR_S_BIT]) |=> !priv_viol);

    assert_reject_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_is_addr && wr_size == 2'b00) |=> wr_reject);

    assert_reject_only_when_due_R5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_is_addr && wr_size == 2'b00) |=> !wr_reject);

    assert_port_beats_flags_R13: assert property (@(posedge clk) disable iff (rst)
        (sr_wr_en && wr_en && !wr_is_addr) |=>
            sr_out[7:0] == ($past(sr_wr_data[7:0]) & SR_DEFINED[7:0]));

endmodule

bind cpu_regbank regbank_checker #(.NREGS(NREGS)) chk_i (.*);

// File: tb/cpu_regbank_tb_top.sv
`timescale 1ns/1ps
module cpu_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 0, wr_is_addr = 0;
    logic [2:0]  wr_idx = 0;
    logic [1:0]  wr_size = 0;
    logic [31:0] wr_data = 0;
    logic [4:0]  cc_in = 0;
    logic        sr_wr_en = 0, sr_wr_hi = 0;
    logic [15:0] sr_wr_data = 0;
    logic        rd_a_is_addr = 0, rd_b_is_addr = 0;
    logic [2:0]  rd_a_idx = 0, rd_b_idx = 0;
    logic [31:0] rd_a_data, rd_b_data;
    logic [15:0] sr_out;
    logic        wr_reject, priv_viol;

    always #2 clk = ~clk;

    cpu_regbank dut_i (.*);

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Monitor: pops expected items and compares against the live outputs
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (q.size() != 0);
            it = q.pop_front();
            case (it.kind)
                0: act = rd_a_data;
                1: act = rd_b_data;
                2: act = {16'h0, sr_out};
                3: act = {31'h0, priv_viol};
                default: act = {31'h0, wr_reject};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_item(input int kind, input logic [31:0] exp, input string tag);
        q.push_back('{kind, exp, tag});
        wait (q.size() == 0);
        #0;
    endtask

    task automatic read_a(input logic is_addr, input logic [2:0] idx,
                          input logic [31:0] exp, input string tag);
        rd_a_is_addr = is_addr; rd_a_idx = idx; #0.1;
        expect_item(0, exp, tag);
    endtask

    task automatic read_b(input logic is_addr, input logic [2:0] idx,
                          input logic [31:0] exp, input string tag);
        rd_b_is_addr = is_addr; rd_b_idx = idx; #0.1;
        expect_item(1, exp, tag);
    endtask

    task automatic reg_write(input logic is_addr, input logic [2:0] idx,
                             input logic [1:0] sz, input logic [31:0] d,
                             input logic [4:0] cc);
        wr_en = 1; wr_is_addr = is_addr; wr_idx = idx; wr_size = sz;
        wr_data = d; cc_in = cc;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic sr_write(input logic hi, input logic [15:0] d);
        sr_wr_en = 1; sr_wr_hi = hi; sr_wr_data = d;
        @(negedge clk);
        sr_wr_en = 0; sr_wr_hi = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R12 reset state
        expect_item(2, 32'h2700, "R12 status after reset");
        expect_item(3, 0, "R12 viol low");
        expect_item(4, 0, "R12 reject low");
        read_a(0, 0, 32'h0, "R12 D0 cleared");
        read_b(1, 7, 32'h0, "R12 A7 cleared");

        // R1 / R3 long data write
        reg_write(0, 3, 2'b10, 32'h12345678, 5'b10101);
        read_a(0, 3, 32'h12345678, "R1 D3 long");
        expect_item(2, 32'h2715, "R3 flags loaded");

        // R2 byte then word into D3
        reg_write(0, 3, 2'b00, 32'hFFFFFFAB, 5'b00100);
        read_a(0, 3, 32'h123456AB, "R2 byte keeps upper");
        expect_item(2, 32'h2704, "R3 flags second write");
        reg_write(0, 3, 2'b01, 32'h0000BEEF, 5'b00000);
        read_a(0, 3, 32'h1234BEEF, "R2 word keeps upper");

        // R4 / R6 address writes
        reg_write(1, 2, 2'b01, 32'h00008001, 5'b11111);
        read_a(1, 2, 32'hFFFF8001, "R4 word sign extended");
        expect_item(2, 32'h2700, "R6 status untouched");
        reg_write(1, 2, 2'b10, 32'h00400000, 5'b11111);
        read_b(1, 2, 32'h00400000, "R4 long addr via R10 index port");

        // R5 byte write to address file rejected
        reg_write(1, 2, 2'b00, 32'h00000055, 5'b0);
        expect_item(4, 1, "R5 reject pulse");
        read_a(1, 2, 32'h00400000, "R5 A2 unchanged");
        @(negedge clk);
        expect_item(4, 0, "R5 reject single cycle");

        // R11 same-cycle read returns old value
        wr_en = 1; wr_is_addr = 0; wr_idx = 5; wr_size = 2'b10;
        wr_data = 32'hCAFEF00D; cc_in = 0;
        read_a(0, 5, 32'h0, "R11 old value during write");
        @(negedge clk);
        wr_en = 0;
        read_a(0, 5, 32'hCAFEF00D, "R11 new value after edge");
        read_b(0, 5, 32'hCAFEF00D, "R10 index port reads data reg");

        // R8 supervisor stack pointer
        reg_write(1, 7, 2'b10, 32'h0000F000, 5'b0);
        read_a(1, 7, 32'h0000F000, "R8 supervisor copy");

        // R7 supervisor full write; reserved bits drop
        sr_write(1, 16'hFFFF);
        expect_item(2, 32'hA71F, "R7 defined bits only");

        // R13 status port beats flags
        sr_wr_en = 1; sr_wr_hi = 0; sr_wr_data = 16'h0011;
        reg_write(0, 1, 2'b10, 32'h1, 5'b00000);
        sr_wr_en = 0;
        expect_item(2, 32'hA711, "R13 port value wins");

        // leave supervisor mode
        sr_write(1, 16'h0000);
        expect_item(2, 32'h0000, "R7 supervisor clears S");

        // R8 user stack pointer
        read_a(1, 7, 32'h0, "R8 user copy separate");
        reg_write(1, 7, 2'b10, 32'h00001000, 5'b0);
        read_a(1, 7, 32'h00001000, "R8 user copy written");
        read_b(1, 7, 32'h00001000, "R8 user copy on index port");
        expect_item(2, 32'h0000, "R6 stack write leaves status");

        // R9 user mode privileged write attempt
        sr_write(1, 16'h2705);
        expect_item(3, 1, "R9 violation pulse");
        expect_item(2, 32'h0005, "R9 only flag byte written");
        @(negedge clk);
        expect_item(3, 0, "R9 pulse single cycle");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule